// File: doc/BRIEF.md
# Register File with Shadow Condition and Translation Hints

This block is a general-purpose register file of 32 entries of 64 bits, with two read ports and one write port. Beside each entry it keeps hidden attributes that the instruction set never sees. A zero flag is recomputed from the data on every write, whatever the source of that write. The lowest and highest data bits are presented directly on each read port, so that conditional logic can test a register without an arithmetic pass. A translation-valid hint bit records that the value was last seen as an address whose translation is known good. A later address use may then skip a lookup. A wrong hint costs only time and never changes a result.

Each write carries a kind: computation, memory load, context restore or register copy. A copy takes its hint from the source entry, named by a separate source index. Every other kind takes the hint the writer supplies, which is normally zero. An invalidate-all input clears every hint in one cycle, for example when translations are flushed. Entry 0 is hardwired to zero. A read of the entry being written in the same cycle returns the new value and its new attributes.

The block has no sequencing of its own. It holds the per-entry state registers and the combinational read paths, and has no state machine.

Top module: `shadow_regfile`

## Requirements
- R1: A write with wr_en high to a non-zero index stores wr_data. From the next cycle, reads of that index return the data with the zero flag high exactly when the data is all zeros. This holds for every write kind, including context restore.
- R2: On each read port, the lsb output equals bit 0 and the msb output equals bit 63 of the returned data.
- R3: A write with wr_kind = 3 (copy) sets the destination hint to the current hint of the entry named by wr_src_idx and ignores wr_hint_in.
- R4: A write with wr_kind = 0 (compute), 1 (load) or 2 (restore) sets the destination hint to wr_hint_in.
- R5: While inval_all is high, both read ports return hint 0. From the next cycle, every entry's hint is 0, including the hint of an entry written in that same cycle. Data and zero flags are untouched.
- R6: Index 0 always reads data 0, zero flag 1 and hint 0. Writes to index 0 have no effect.
- R7: A read whose index matches a write to a non-zero index in the same cycle returns that write's data, its zero flag and its resulting hint.
- R8: After reset every entry reads data 0, zero flag 1 and hint 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Destination entry index |
| wr_data | input | 64 | Data to write |
| wr_kind | input | 2 | 0 compute, 1 load, 2 restore, 3 copy |
| wr_src_idx | input | 5 | Source entry of a copy, used for its hint |
| wr_hint_in | input | 1 | Hint supplied by a non-copy writer |
| inval_all | input | 1 | Clear every translation-valid hint |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_data | output | 64 | Port A data |
| rd_a_zero | output | 1 | Port A zero flag |
| rd_a_lsb | output | 1 | Port A bit 0 |
| rd_a_msb | output | 1 | Port A bit 63 |
| rd_a_hint | output | 1 | Port A translation-valid hint |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_data | output | 64 | Port B data |
| rd_b_zero | output | 1 | Port B zero flag |
| rd_b_lsb | output | 1 | Port B bit 0 |
| rd_b_msb | output | 1 | Port B bit 63 |
| rd_b_hint | output | 1 | Port B translation-valid hint |

## Verification
Two pairs of functions can coincide in one cycle. The first pair is a write and a read of the same entry. The bench sets the write and both read indices at the same falling edge and samples before the next rising edge, where it expects the new data, the recomputed zero flag and the new hint. The second pair is a hint invalidation and a write that supplies a valid hint. The bench raises both together and expects the read hint to be 0 during that cycle and the written entry to hold the new data with its hint cleared afterwards.

// File: rtl/srf_pkg.sv
package srf_pkg;
    typedef enum logic [1:0] {
        WK_COMPUTE = 2'd0,
        WK_LOAD    = 2'd1,
        WK_RESTORE = 2'd2,
        WK_COPY    = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/srf_entry.sv
module srf_entry #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         whint,
    input  logic         inval,
    output logic [W-1:0] q_data,
    output logic         q_zero,
    output logic         q_hint
);
    logic [W-1:0] data_q;
    logic         zero_q;
    logic         hint_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            zero_q <= 1'b1;
            hint_q <= 1'b0;
        end else begin
            if (we) begin
                data_q <= wdata;
                zero_q <= (wdata == '0);
            end
            if (we)
                hint_q <= whint & ~inval;
            else if (inval)
                hint_q <= 1'b0;
        end
    end

    assign q_data = data_q;
    assign q_zero = zero_q;
    assign q_hint = hint_q;

    // R1: the stored zero flag always agrees with the stored data
    assert_zero_tracks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q == (data_q == '0));
endmodule

// File: rtl/srf_read_port.sv
module srf_read_port #(
    parameter int W  = 64,
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  ent_data [N],
    input  logic [N-1:0]  ent_zero,
    input  logic [N-1:0]  ent_hint,
    input  logic          byp_en,
    input  logic [IW-1:0] byp_idx,
    input  logic [W-1:0]  byp_data,
    input  logic          byp_hint,
    input  logic          inval,
    output logic [W-1:0]  data,
    output logic          zero,
    output logic          lsb,
    output logic          msb,
    output logic          hint
);
    always_comb begin
        if (byp_en && (byp_idx == idx)) begin
            data = byp_data;
            zero = (byp_data == '0);
            hint = byp_hint;
        end else begin
            data = ent_data[idx];
            zero = ent_zero[idx];
            hint = ent_hint[idx] & ~inval;
        end
    end

    assign lsb = data[0];
    assign msb = data[W-1];
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
    import srf_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        wr_kind,
    input  logic [IDX_W-1:0]  wr_src_idx,
    input  logic              wr_hint_in,
    input  logic              inval_all,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_zero,
    output logic              rd_a_lsb,
    output logic              rd_a_msb,
    output logic              rd_a_hint,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              rd_b_zero,
    output logic              rd_b_lsb,
    output logic              rd_b_msb,
    output logic              rd_b_hint
);
    logic [DATA_W-1:0]   ent_data [NUM_REGS];
    logic [NUM_REGS-1:0] ent_zero;
    logic [NUM_REGS-1:0] ent_hint;

    logic wr_live;
    logic wr_is_copy;
    logic hint_sel;
    logic hint_eff;

    assign wr_live    = wr_en && (wr_idx != '0);
    assign wr_is_copy = (wr_kind_e'(wr_kind) == WK_COPY);
    assign hint_sel   = wr_is_copy ? ent_hint[wr_src_idx] : wr_hint_in;
    assign hint_eff   = hint_sel & ~inval_all;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
        if (i == 0) begin : g_zero
            assign ent_data[i] = '0;
            assign ent_zero[i] = 1'b1;
            assign ent_hint[i] = 1'b0;
        end else begin : g_reg
            srf_entry #(.W(DATA_W)) u_entry (
                .clk    (clk),
                .rst_n  (rst_n),
                .we     (wr_live && (wr_idx == IDX_W'(i))),
                .wdata  (wr_data),
                .whint  (hint_sel),
                .inval  (inval_all),
                .q_data (ent_data[i]),
                .q_zero (ent_zero[i]),
                .q_hint (ent_hint[i])
            );
        end
    end

    srf_read_port #(.W(DATA_W), .N(NUM_REGS), .IW(IDX_W)) u_port_a (
        .idx(rd_a_idx), .ent_data(ent_data), .ent_zero(ent_zero), .ent_hint(ent_hint),
        .byp_en(wr_live), .byp_idx(wr_idx), .byp_data(wr_data), .byp_hint(hint_eff),
        .inval(inval_all), .data(rd_a_data), .zero(rd_a_zero), .lsb(rd_a_lsb),
        .msb(rd_a_msb), .hint(rd_a_hint)
    );

    srf_read_port #(.W(DATA_W), .N(NUM_REGS), .IW(IDX_W)) u_port_b (
        .idx(rd_b_idx), .ent_data(ent_data), .ent_zero(ent_zero), .ent_hint(ent_hint),
        .byp_en(wr_live), .byp_idx(wr_idx), .byp_data(wr_data), .byp_hint(hint_eff),
        .inval(inval_all), .data(rd_b_data), .zero(rd_b_zero), .lsb(rd_b_lsb),
        .msb(rd_b_msb), .hint(rd_b_hint)
    );

    // R1: a completed write is visible on port A in the following cycle
    assert_write_seen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_live |=> (rd_a_idx != $past(wr_idx)) || (wr_en && (wr_idx == rd_a_idx)) ||
                    ((rd_a_data == $past(wr_data)) && (rd_a_zero == ($past(wr_data) == '0))));

    // R5: no hint is reported while invalidation is requested
    assert_inval_hint_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |-> (!rd_a_hint && !rd_b_hint));

    // R6: entry 0 is constant on port B
    assert_reg0_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == '0) |-> ((rd_b_data == '0) && rd_b_zero && !rd_b_hint));

    // R7: same-cycle read of the written entry returns the written data
    assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_live && (rd_b_idx == wr_idx)) |-> (rd_b_data == wr_data));
endmodule

// File: tb/tb_shadow_regfile.sv
module tb_shadow_regfile;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  wr_kind = '0;
    logic [4:0]  wr_src_idx = '0;
    logic        wr_hint_in = 1'b0;
    logic        inval_all = 1'b0;
    logic [4:0]  rd_a_idx = '0;
    logic [63:0] rd_a_data;
    logic        rd_a_zero, rd_a_lsb, rd_a_msb, rd_a_hint;
    logic [4:0]  rd_b_idx = '0;
    logic [63:0] rd_b_data;
    logic        rd_b_zero, rd_b_lsb, rd_b_msb, rd_b_hint;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    shadow_regfile dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_kind(wr_kind), .wr_src_idx(wr_src_idx), .wr_hint_in(wr_hint_in),
        .inval_all(inval_all),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_zero(rd_a_zero),
        .rd_a_lsb(rd_a_lsb), .rd_a_msb(rd_a_msb), .rd_a_hint(rd_a_hint),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_zero(rd_b_zero),
        .rd_b_lsb(rd_b_lsb), .rd_b_msb(rd_b_msb), .rd_b_hint(rd_b_hint)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_a(string req, logic [63:0] d, logic z, logic h);
        chk(req, "a data", rd_a_data, d);
        chk(req, "a zero", {63'd0, rd_a_zero}, {63'd0, z});
        chk(req, "a hint", {63'd0, rd_a_hint}, {63'd0, h});
        chk("R2", "a lsb", {63'd0, rd_a_lsb}, {63'd0, d[0]});
        chk("R2", "a msb", {63'd0, rd_a_msb}, {63'd0, d[63]});
    endtask

    task automatic chk_b(string req, logic [63:0] d, logic z, logic h);
        chk(req, "b data", rd_b_data, d);
        chk(req, "b zero", {63'd0, rd_b_zero}, {63'd0, z});
        chk(req, "b hint", {63'd0, rd_b_hint}, {63'd0, h});
        chk("R2", "b lsb", {63'd0, rd_b_lsb}, {63'd0, d[0]});
        chk("R2", "b msb", {63'd0, rd_b_msb}, {63'd0, d[63]});
    endtask

    // write at a falling edge, committed on the rising edge, released at the next falling edge
    task automatic wr(logic [4:0] idx, logic [63:0] d, logic [1:0] kind, logic h, logic [4:0] src);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d; wr_kind = kind;
        wr_hint_in = h; wr_src_idx = src;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [4:0] ia, logic [4:0] ib);
        rd_a_idx = ia; rd_b_idx = ib;
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rd(5'd5, 5'd31);
        chk_a("R8", 64'd0, 1'b1, 1'b0);
        chk_b("R8", 64'd0, 1'b1, 1'b0);
    endtask

    task automatic t_write;
        wr(5'd3, 64'h8000_0000_0000_0001, 2'd0, 1'b0, 5'd0);
        rd(5'd3, 5'd3);
        chk_a("R1", 64'h8000_0000_0000_0001, 1'b0, 1'b0);
        chk_b("R1", 64'h8000_0000_0000_0001, 1'b0, 1'b0);
        wr(5'd4, 64'd0, 2'd0, 1'b0, 5'd0);
        wr(5'd5, 64'h2, 2'd1, 1'b0, 5'd0);
        rd(5'd4, 5'd5);
        chk_a("R1", 64'd0, 1'b1, 1'b0);
        chk_b("R1", 64'h2, 1'b0, 1'b0);
    endtask

    task automatic t_hint_kinds;
        wr(5'd6, 64'h1000, 2'd1, 1'b1, 5'd0);
        rd(5'd6, 5'd0);
        chk_a("R4", 64'h1000, 1'b0, 1'b1);
        wr(5'd7, 64'd0, 2'd2, 1'b0, 5'd6);
        rd(5'd7, 5'd0);
        chk_a("R1", 64'd0, 1'b1, 1'b0);
        wr(5'd7, 64'h7FFF_0000_0000_0000, 2'd2, 1'b1, 5'd0);
        rd(5'd7, 5'd0);
        chk_a("R4", 64'h7FFF_0000_0000_0000, 1'b0, 1'b1);
        wr(5'd6, 64'h1004, 2'd0, 1'b0, 5'd7);
        rd(5'd6, 5'd0);
        chk_a("R4", 64'h1004, 1'b0, 1'b0);
    endtask

    task automatic t_copy;
        wr(5'd8, 64'h4000, 2'd1, 1'b1, 5'd0);
        wr(5'd9, 64'h4000, 2'd3, 1'b0, 5'd8);
        rd(5'd9, 5'd8);
        chk_a("R3", 64'h4000, 1'b0, 1'b1);
        wr(5'd10, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 5'd3);
        rd(5'd10, 5'd0);
        chk_a("R3", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    endtask

    task automatic t_inval;
        @(negedge clk);
        inval_all = 1'b1;
        rd(5'd8, 5'd9);
        chk_a("R5", 64'h4000, 1'b0, 1'b0);
        chk_b("R5", 64'h4000, 1'b0, 1'b0);
        @(negedge clk);
        inval_all = 1'b0;
        rd(5'd8, 5'd7);
        chk_a("R5", 64'h4000, 1'b0, 1'b0);
        chk_b("R5", 64'h7FFF_0000_0000_0000, 1'b0, 1'b0);
        @(negedge clk);
        inval_all = 1'b1;
        wr_en = 1'b1; wr_idx = 5'd11; wr_data = 64'h55; wr_kind = 2'd1; wr_hint_in = 1'b1;
        rd(5'd11, 5'd0);
        chk_a("R5", 64'h55, 1'b0, 1'b0);
        @(negedge clk);
        inval_all = 1'b0; wr_en = 1'b0;
        rd(5'd11, 5'd0);
        chk_a("R5", 64'h55, 1'b0, 1'b0);
    endtask

    task automatic t_reg0;
        wr(5'd0, 64'h8000_0000_0000_00FF, 2'd1, 1'b1, 5'd0);
        rd(5'd0, 5'd0);
        chk_a("R6", 64'd0, 1'b1, 1'b0);
        chk_b("R6", 64'd0, 1'b1, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd0; wr_data = 64'h1234; wr_kind = 2'd0; wr_hint_in = 1'b1;
        rd(5'd0, 5'd0);
        chk_a("R6", 64'd0, 1'b1, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_bypass;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd12; wr_data = 64'h8000_0000_0000_0ABC;
        wr_kind = 2'd1; wr_hint_in = 1'b1;
        rd(5'd12, 5'd12);
        chk_a("R7", 64'h8000_0000_0000_0ABC, 1'b0, 1'b1);
        chk_b("R7", 64'h8000_0000_0000_0ABC, 1'b0, 1'b1);
        @(negedge clk);
        wr_data = 64'd0; wr_kind = 2'd0; wr_hint_in = 1'b0;
        rd(5'd12, 5'd3);
        chk_a("R7", 64'd0, 1'b1, 1'b0);
        chk_b("R7", 64'h8000_0000_0000_0001, 1'b0, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        rd(5'd12, 5'd0);
        chk_a("R1", 64'd0, 1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_hint_kinds();
        t_copy();
        t_inval();
        t_reg0();
        t_bypass();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule